// File: doc/BRIEF.md
# Descriptor-Driven Audio Stream DMA Engine

This block serves a set of audio streams, half of them capture (input) and half playback (output). Software programs each stream with a stream number, a cyclic buffer length, a last valid descriptor index and the base address of a descriptor list in host memory, then sets the stream's run bit. The engine then reads the stream's first descriptor from memory. A codec-side transfer request names a direction, a stream number and a byte count. The engine turns that request into a series of memory chunk commands, each one bounded by the descriptor in use and by the cyclic buffer.

The engine tracks a link position per stream and an offset within the current descriptor. It moves on to the next descriptor, and reads it, once the current one is used up, and it wraps both the descriptor index and the link position. A descriptor that carries the completion flag raises a per-stream status bit and the interrupt line. While that status bit is set, the stream refuses further requests, so software must acknowledge before data flows again. When position write-back is enabled, the link position is stored to memory after each transfer.

Top module: `dma_stream_engine`

## Requirements
- R1: Streams 0 to NUM_STREAMS/2-1 are input streams and the rest are output streams. A request goes to the lowest-indexed stream of the requested direction whose control bits 23:20 equal the requested number. Chunks of input streams are issued with cmd_to_mem=1 and chunks of output streams with cmd_to_mem=0.
- R2: A control write that sets bit 1 (run) while the stream is stopped loads descriptor 0. Descriptor i sits at list base + 16*i and is made of four 32-bit words read at ascending addresses: address low, address high, length, flags. Flag bit 0 requests a completion interrupt.
- R3: Each chunk length is the smallest of the bytes left in the request, the cyclic buffer length minus the link position, and the descriptor length minus the offset within the descriptor. A chunk is never zero bytes. It targets descriptor address + offset.
- R4: When a descriptor is used up, the engine moves to the next index and reads that descriptor, wrapping to index 0 after the last valid index.
- R5: The link position (register select 7) advances by each chunk and wraps to 0 when it reaches the cyclic buffer length.
- R6: Using up a descriptor whose flag bit 0 is set sets control status bit 26 and drives irq high.
- R7: While bit 26 is set, a request for that stream fails with no chunk. Writing 1 to bit 26 of the control word clears it and lowers irq.
- R8: If bit 0 of the position base low word is set, a single word write of the link position to (base with bit 0 cleared) + 8*stream index follows the last chunk of every successful transfer.
- R9: Control bit 0 holds the stream in reset, which clears its link position, descriptor state and bit 26.
- R10: A request to a stream that is unmatched, not running or without a loaded descriptor completes with xfer_ok=0 and issues no chunk and no memory access.
- R11: xfer_done is a one-cycle pulse. xfer_ready is high only when the engine is idle with no descriptor load pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 control, 1 cyclic length, 2 last index, 3/4 list base low/high, 5/6 position base low/high, 7 link position (read) |
| reg_stream | input | SW | Stream addressed by the register access |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel/reg_stream |
| xfer_valid | input | 1 | Transfer request valid |
| xfer_ready | output | 1 | Engine can accept a request |
| xfer_out | input | 1 | 1 = output (playback) direction |
| xfer_stnr | input | 4 | Requested stream number |
| xfer_len | input | 32 | Requested byte count |
| xfer_done | output | 1 | Request completed (pulse) |
| xfer_ok | output | 1 | Completion status, valid with xfer_done |
| cmd_valid | output | 1 | Chunk command valid |
| cmd_to_mem | output | 1 | Chunk writes host memory |
| cmd_addr | output | 64 | Chunk host address |
| cmd_len | output | 32 | Chunk byte count |
| mem_rd | output | 1 | Word read request (data returned next cycle) |
| mem_wr | output | 1 | Word write request |
| mem_addr | output | 64 | Word address |
| mem_wdata | output | 32 | Word write data |
| mem_rdata | input | 32 | Word read data, one cycle after mem_rd |
| irq | output | 1 | Any stream's completion status set |

## Verification
The assertions check on every cycle that no chunk is ever zero bytes, that the idle engine drives no memory traffic, that completion is a single-cycle pulse, that a position write is immediately followed by completion, and that the interrupt only rises straight after a chunk. The bench scenarios are needed for the arithmetic: the three-way chunk split, where the link position and descriptor index wrap, how descriptors are fetched, which direction a stream maps to, and the stall-and-acknowledge sequence. These depend on programmed values and on history across several requests.

// File: rtl/dma_stream_pkg.sv
package dma_stream_pkg;
    localparam int LEN_W  = 32;
    localparam int ADDR_W = 64;
    localparam int IDX_W  = 8;
    localparam int NUM_W  = 4;

    typedef enum logic [2:0] {
        SEL_CTL = 3'd0, SEL_CBL = 3'd1, SEL_LVI = 3'd2, SEL_BDL_LO = 3'd3,
        SEL_BDL_HI = 3'd4, SEL_POS_LO = 3'd5, SEL_POS_HI = 3'd6, SEL_LPIB = 3'd7
    } reg_sel_e;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_COPY, S_POSWR, S_DONE
    } fsm_e;

    typedef struct packed {
        logic              srst;
        logic              run;
        logic              bcis;
        logic              loaded;
        logic              need;
        logic [NUM_W-1:0]  stnr;
        logic [LEN_W-1:0]  cbl;
        logic [LEN_W-1:0]  lpib;
        logic [LEN_W-1:0]  off;
        logic [LEN_W-1:0]  dlen;
        logic [IDX_W-1:0]  lvi;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] bdl;
        logic [ADDR_W-1:0] daddr;
        logic              dioc;
    } strm_t;
endpackage

// File: rtl/dma_chunk_calc.sv
module dma_chunk_calc #(
    parameter int W = 32
) (
    input  logic [W-1:0] left,
    input  logic [W-1:0] cbl,
    input  logic [W-1:0] lpib,
    input  logic [W-1:0] dlen,
    input  logic [W-1:0] off,
    output logic [W-1:0] chunk
);
    logic [W-1:0] room_buf, room_desc, m0;
    always_comb begin
        room_buf  = cbl - lpib;
        room_desc = dlen - off;
        m0        = (left < room_buf) ? left : room_buf;
        chunk     = (m0 < room_desc) ? m0 : room_desc;
    end
endmodule

// File: rtl/dma_stream_match.sv
module dma_stream_match #(
    parameter int NS    = 8,
    parameter int NUM_W = 4,
    localparam int SW   = $clog2(NS),
    localparam int HALF = NS / 2
) (
    input  logic              req_out,
    input  logic [NUM_W-1:0]  req_stnr,
    input  logic [NS*NUM_W-1:0] stnr_flat,
    output logic              hit,
    output logic [SW-1:0]     idx
);
    logic [HALF-1:0] eq_in, eq_out;
    for (genvar j = 0; j < HALF; j++) begin : g_cmp
        assign eq_in[j]  = stnr_flat[j*NUM_W +: NUM_W] == req_stnr;
        assign eq_out[j] = stnr_flat[(HALF+j)*NUM_W +: NUM_W] == req_stnr;
    end
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int j = HALF - 1; j >= 0; j--) begin
            if (req_out ? eq_out[j] : eq_in[j]) begin
                hit = 1'b1;
                idx = req_out ? SW'(HALF + j) : SW'(j);
            end
        end
    end
endmodule

// File: rtl/dma_stream_engine.sv
module dma_stream_engine
    import dma_stream_pkg::*;
#(
    parameter int NS = 8,
    localparam int SW = $clog2(NS),
    localparam int HALF = NS / 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_sel,
    input  logic [SW-1:0] reg_stream,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        xfer_valid,
    output logic        xfer_ready,
    input  logic        xfer_out,
    input  logic [3:0]  xfer_stnr,
    input  logic [31:0] xfer_len,
    output logic        xfer_done,
    output logic        xfer_ok,
    output logic        cmd_valid,
    output logic        cmd_to_mem,
    output logic [63:0] cmd_addr,
    output logic [31:0] cmd_len,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [63:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    output logic        irq
);
    typedef struct packed {
        strm_t [NS-1:0]   s;
        fsm_e             st;
        fsm_e             resume;
        logic [SW-1:0]    cur;
        logic [LEN_W-1:0] left;
        logic [2:0]       wcnt;
        logic             ok;
        logic [31:0]      pos_lo;
        logic [31:0]      pos_hi;
    } eng_t;

    eng_t q, d;

    // per-stream number vector for the matcher
    logic [NS*NUM_W-1:0] stnr_flat;
    for (genvar i = 0; i < NS; i++) begin : g_flat
        assign stnr_flat[i*NUM_W +: NUM_W] = q.s[i].stnr;
    end

    logic          m_hit;
    logic [SW-1:0] m_idx;
    dma_stream_match #(.NS(NS), .NUM_W(NUM_W)) u_match (
        .req_out(xfer_out), .req_stnr(xfer_stnr), .stnr_flat(stnr_flat),
        .hit(m_hit), .idx(m_idx)
    );

    strm_t        cs;
    logic [LEN_W-1:0] chunk;
    assign cs = q.s[q.cur];
    dma_chunk_calc #(.W(LEN_W)) u_chunk (
        .left(q.left), .cbl(cs.cbl), .lpib(cs.lpib),
        .dlen(cs.dlen), .off(cs.off), .chunk(chunk)
    );

    logic need_any;
    logic [SW-1:0] need_idx;
    logic [NS-1:0] bcis_vec;
    always_comb begin
        need_any = 1'b0;
        need_idx = '0;
        for (int i = NS - 1; i >= 0; i--) begin
            bcis_vec[i] = q.s[i].bcis;
            if (q.s[i].need) begin
                need_any = 1'b1;
                need_idx = SW'(i);
            end
        end
    end

    logic [LEN_W-1:0] adv_off, adv_lpib;
    assign adv_off  = cs.off + chunk;
    assign adv_lpib = cs.lpib + chunk;
    logic copy_go;
    assign copy_go = (q.st == S_COPY) && (q.left != '0) && (chunk != '0);

    always_comb begin
        d = q;
        // register writes
        if (reg_we) begin
            case (reg_sel_e'(reg_sel))
                SEL_CTL: begin
                    if (reg_wdata[1] && !q.s[reg_stream].run) begin
                        d.s[reg_stream].need   = 1'b1;
                        d.s[reg_stream].loaded = 1'b0;
                        d.s[reg_stream].idx    = '0;
                        d.s[reg_stream].off    = '0;
                    end
                    d.s[reg_stream].srst = reg_wdata[0];
                    d.s[reg_stream].run  = reg_wdata[1];
                    d.s[reg_stream].stnr = reg_wdata[23:20];
                    if (reg_wdata[26]) d.s[reg_stream].bcis = 1'b0;
                end
                SEL_CBL:    d.s[reg_stream].cbl = reg_wdata;
                SEL_LVI:    d.s[reg_stream].lvi = reg_wdata[IDX_W-1:0];
                SEL_BDL_LO: d.s[reg_stream].bdl[31:0]  = reg_wdata;
                SEL_BDL_HI: d.s[reg_stream].bdl[63:32] = reg_wdata;
                SEL_POS_LO: d.pos_lo = reg_wdata;
                SEL_POS_HI: d.pos_hi = reg_wdata;
                default: ;
            endcase
        end
        // streams held in reset
        for (int i = 0; i < NS; i++) begin
            if (d.s[i].srst) begin
                d.s[i].lpib   = '0;
                d.s[i].idx    = '0;
                d.s[i].off    = '0;
                d.s[i].loaded = 1'b0;
                d.s[i].need   = 1'b0;
                d.s[i].bcis   = 1'b0;
            end
        end
        // sequencer
        case (q.st)
            S_IDLE: begin
                if (need_any) begin
                    d.cur = need_idx;
                    d.s[need_idx].need = 1'b0;
                    d.wcnt   = '0;
                    d.resume = S_IDLE;
                    d.st     = S_FETCH;
                end else if (xfer_valid) begin
                    if (m_hit && q.s[m_idx].run && q.s[m_idx].loaded && !q.s[m_idx].bcis) begin
                        d.cur  = m_idx;
                        d.left = xfer_len;
                        d.st   = S_COPY;
                    end else begin
                        d.ok = 1'b0;
                        d.st = S_DONE;
                    end
                end
            end
            S_FETCH: begin
                d.wcnt = q.wcnt + 3'd1;
                case (q.wcnt)
                    3'd1: d.s[q.cur].daddr[31:0]  = mem_rdata;
                    3'd2: d.s[q.cur].daddr[63:32] = mem_rdata;
                    3'd3: d.s[q.cur].dlen         = mem_rdata;
                    3'd4: begin
                        d.s[q.cur].dioc   = mem_rdata[0];
                        d.s[q.cur].loaded = 1'b1;
                        d.st = q.resume;
                    end
                    default: ;
                endcase
            end
            S_COPY: begin
                if (!copy_go) begin
                    d.ok = 1'b1;
                    d.st = q.pos_lo[0] ? S_POSWR : S_DONE;
                end else begin
                    d.left = q.left - chunk;
                    d.s[q.cur].lpib = (adv_lpib == cs.cbl) ? '0 : adv_lpib;
                    d.s[q.cur].off  = adv_off;
                    if (adv_off == cs.dlen) begin
                        if (cs.dioc) d.s[q.cur].bcis = 1'b1;
                        d.s[q.cur].idx = (cs.idx == cs.lvi) ? '0 : cs.idx + 1'b1;
                        d.s[q.cur].off = '0;
                        d.wcnt   = '0;
                        d.resume = S_COPY;
                        d.st     = S_FETCH;
                    end
                end
            end
            S_POSWR: d.st = S_DONE;
            S_DONE:  d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
            q.st <= S_IDLE;
            q.resume <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    // outputs
    always_comb begin
        xfer_ready = (q.st == S_IDLE) && !need_any;
        xfer_done  = (q.st == S_DONE);
        xfer_ok    = q.ok;
        cmd_valid  = copy_go;
        cmd_to_mem = (q.cur < SW'(HALF));
        cmd_addr   = cs.daddr + {32'b0, cs.off};
        cmd_len    = chunk;
        mem_rd     = (q.st == S_FETCH) && (q.wcnt < 3'd4);
        mem_wr     = (q.st == S_POSWR);
        mem_wdata  = cs.lpib;
        if (q.st == S_POSWR)
            mem_addr = {q.pos_hi, q.pos_lo[31:1], 1'b0} + (64'(q.cur) << 3);
        else
            mem_addr = cs.bdl + (64'(cs.idx) << 4) + (64'(q.wcnt) << 2);
        irq = |bcis_vec;
        case (reg_sel_e'(reg_sel))
            SEL_CTL:    reg_rdata = {5'b0, q.s[reg_stream].bcis, 2'b0, q.s[reg_stream].stnr,
                                     18'b0, q.s[reg_stream].run, q.s[reg_stream].srst};
            SEL_CBL:    reg_rdata = q.s[reg_stream].cbl;
            SEL_LVI:    reg_rdata = 32'(q.s[reg_stream].lvi);
            SEL_BDL_LO: reg_rdata = q.s[reg_stream].bdl[31:0];
            SEL_BDL_HI: reg_rdata = q.s[reg_stream].bdl[63:32];
            SEL_POS_LO: reg_rdata = q.pos_lo;
            SEL_POS_HI: reg_rdata = q.pos_hi;
            default:    reg_rdata = q.s[reg_stream].lpib;
        endcase
    end
endmodule

// File: rtl/dma_stream_chk.sv
module dma_stream_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [31:0] cmd_len,
    input logic        xfer_ready,
    input logic        xfer_done,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic        irq
);
    assert_chunk_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_len != 32'd0);
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_ready |-> (!cmd_valid && !mem_rd && !mem_wr));
    assert_irq_after_chunk_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(cmd_valid));
    assert_pos_then_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> xfer_done);
endmodule

bind dma_stream_engine dma_stream_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_len(cmd_len),
    .xfer_ready(xfer_ready), .xfer_done(xfer_done), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .irq(irq)
);

// File: tb/sim_dma_stream_engine.sv
module sim_dma_stream_engine;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, reg_we, xfer_valid, xfer_out;
    logic [2:0] reg_sel;
    logic [2:0] reg_stream;
    logic [31:0] reg_wdata, reg_rdata, xfer_len, cmd_len, mem_wdata;
    logic [3:0] xfer_stnr;
    logic xfer_ready, xfer_done, xfer_ok, cmd_valid, cmd_to_mem, mem_rd, mem_wr, irq;
    logic [63:0] cmd_addr, mem_addr;
    logic [31:0] mem_rdata;
    logic [31:0] memw [256];

    dma_stream_engine u0 (.*);

    always @(posedge clk) mem_rdata <= memw[mem_addr[9:2]];

    int n_chk = 0, n_bad = 0, cyc = 0;
    int nchunks;
    logic [63:0] f_addr, l_addr, pw_addr;
    logic [31:0] f_len, l_len, pw_data;
    logic l_to_mem, pw_seen, done_seen, done_ok;

    always @(negedge clk) begin
        if (cmd_valid) begin
            if (nchunks == 0) begin f_addr <= cmd_addr; f_len <= cmd_len; end
            l_addr <= cmd_addr; l_len <= cmd_len; l_to_mem <= cmd_to_mem;
            nchunks <= nchunks + 1;
        end
        if (mem_wr) begin pw_seen <= 1'b1; pw_addr <= mem_addr; pw_data <= mem_wdata; end
        if (xfer_done) begin done_seen <= 1'b1; done_ok <= xfer_ok; end
    end

    task automatic chk(input logic c, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!c) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below 100000", cyc);
            finish_run();
        end
    end

    task automatic wr(input logic [2:0] s, input logic [2:0] sel, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_stream = s; reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, input logic [2:0] sel, output logic [31:0] v);
        @(negedge clk);
        reg_stream = s; reg_sel = sel;
        #1 v = reg_rdata;
    endtask

    task automatic xfer(input logic dir, input logic [3:0] num, input logic [31:0] len);
        @(negedge clk);
        while (!xfer_ready) @(negedge clk);
        nchunks = 0; pw_seen = 1'b0; done_seen = 1'b0;
        xfer_valid = 1'b1; xfer_out = dir; xfer_stnr = num; xfer_len = len;
        @(negedge clk);
        xfer_valid = 1'b0;
        while (!done_seen) @(posedge clk);
        #1 chk(xfer_done == 1'b0, "R11", "done width", 64'(xfer_done), 0);
    endtask

    // len, chunks, first addr, first len, last addr, last len, link position
    localparam logic [31:0] VEC [4][7] = '{
        '{32'd25, 32'd1, 32'h1000, 32'd25, 32'h1000, 32'd25, 32'd25},
        '{32'd30, 32'd2, 32'h1019, 32'd15, 32'h2000, 32'd15, 32'd55},
        '{32'd50, 32'd4, 32'h200F, 32'd15, 32'h1000, 32'd5,  32'd15},
        '{32'd0,  32'd0, 32'h0,    32'd0,  32'h0,    32'd0,  32'd15}
    };

    logic [31:0] v;
    initial begin
        foreach (memw[i]) memw[i] = 32'h0;
        memw[8'h40] = 32'h1000; memw[8'h42] = 32'd40;
        memw[8'h44] = 32'h2000; memw[8'h46] = 32'd30;
        memw[8'h48] = 32'h3000; memw[8'h4A] = 32'd30;
        memw[8'h80] = 32'h5000; memw[8'h82] = 32'd8; memw[8'h83] = 32'd1;
        rst_n = 1'b0; reg_we = 1'b0; xfer_valid = 1'b0; xfer_out = 1'b0;
        reg_sel = 3'd0; reg_stream = 3'd0; reg_wdata = '0; xfer_stnr = '0; xfer_len = '0;
        nchunks = 0; pw_seen = 0; done_seen = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        rd(3'd1, 3'd7, v);
        chk(v == 0, "R5", "reset link position", 64'(v), 0);
        rd(3'd1, 3'd0, v);
        chk(v == 0, "R9", "reset control", 64'(v), 0);
        chk(xfer_ready && !irq, "R11", "reset ready/irq", {62'b0, xfer_ready, irq}, 64'h2);

        // R10: nothing running
        xfer(1'b0, 4'd5, 32'd10);
        chk(!done_ok && nchunks == 0 && !pw_seen, "R10", "unmatched request",
            {31'b0, done_ok, 32'(nchunks)}, 0);

        // stream 1 (input) and 4 (output), both numbered 5
        wr(3'd1, 3'd1, 32'd90); wr(3'd1, 3'd2, 32'd2); wr(3'd1, 3'd3, 32'h100);
        wr(3'd1, 3'd4, 32'h0);  wr(3'd0, 3'd5, 32'h801); wr(3'd0, 3'd6, 32'h0);
        wr(3'd1, 3'd0, (32'd5 << 20) | 32'h2);

        for (int k = 0; k < 4; k++) begin
            xfer(1'b0, 4'd5, VEC[k][0]);
            chk(done_ok, "R2", "transfer ok", 64'(done_ok), 1);
            chk(nchunks == int'(VEC[k][1]), "R3", "chunk count", 64'(nchunks), 64'(VEC[k][1]));
            if (VEC[k][1] != 0) begin
                chk(f_addr == 64'(VEC[k][2]) && f_len == VEC[k][3], "R3", "first chunk",
                    {f_addr[31:0], f_len}, {VEC[k][2], VEC[k][3]});
                chk(l_addr == 64'(VEC[k][4]) && l_len == VEC[k][5], "R4", "last chunk",
                    {l_addr[31:0], l_len}, {VEC[k][4], VEC[k][5]});
                chk(l_to_mem == 1'b1, "R1", "input direction", 64'(l_to_mem), 1);
            end
            chk(pw_seen && pw_addr == 64'h808 && pw_data == VEC[k][6], "R8", "position write",
                {pw_addr[31:0], pw_data}, {32'h808, VEC[k][6]});
            rd(3'd1, 3'd7, v);
            chk(v == VEC[k][6], "R5", "link position", 64'(v), 64'(VEC[k][6]));
        end

        // output stream with completion flag
        wr(3'd4, 3'd1, 32'd8); wr(3'd4, 3'd2, 32'd0); wr(3'd4, 3'd3, 32'h200);
        wr(3'd4, 3'd0, (32'd5 << 20) | 32'h2);
        xfer(1'b1, 4'd5, 32'd8);
        chk(done_ok && nchunks == 1 && f_addr == 64'h5000 && !l_to_mem, "R1", "output chunk",
            {f_addr[31:0], 31'b0, l_to_mem}, {32'h5000, 32'h0});
        chk(pw_addr == 64'h820 && pw_data == 0, "R5", "wrap to zero",
            {pw_addr[31:0], pw_data}, {32'h820, 32'h0});
        rd(3'd4, 3'd0, v);
        chk(v[26] && irq, "R6", "completion status", {62'b0, v[26], irq}, 64'h3);
        xfer(1'b1, 4'd5, 32'd8);
        chk(!done_ok && nchunks == 0 && !pw_seen, "R7", "stalled request",
            {31'b0, done_ok, 32'(nchunks)}, 0);
        wr(3'd4, 3'd0, (32'd1 << 26) | (32'd5 << 20) | 32'h2);
        rd(3'd4, 3'd0, v);
        chk(!v[26] && !irq, "R7", "acknowledge", {62'b0, v[26], irq}, 0);
        xfer(1'b1, 4'd5, 32'd8);
        chk(done_ok && nchunks == 1 && f_addr == 64'h5000 && f_len == 8, "R4", "single-entry wrap",
            {f_addr[31:0], f_len}, {32'h5000, 32'd8});

        // R9: stream reset
        wr(3'd1, 3'd0, (32'd5 << 20) | 32'h1);
        rd(3'd1, 3'd7, v);
        chk(v == 0, "R9", "reset clears position", 64'(v), 0);
        xfer(1'b0, 4'd5, 32'd4);
        chk(!done_ok && nchunks == 0, "R9", "reset stream refuses",
            {31'b0, done_ok, 32'(nchunks)}, 0);
        finish_run();
    end
endmodule